// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is a wide binary up-counter assembled from identical narrow stages, each stepping on the rising clock edge. Every stage runs one of four named operating modes, which are chosen fresh at each edge from its control inputs. In CLEAR the stage goes to zero. In LOAD it copies its slice of the data input. In COUNT it adds one, wrapping from all ones to zero. In HOLD it keeps its value. The mode is picked by a fixed priority: clear first, then load, then count, and HOLD otherwise. There are no other states. The transition taken on each edge is named after the mode that was active, so the four transitions are clear, load, increment and hold.

Each stage has two active-high enables. The parallel enable only gates counting. The carry enable also gates the stage's terminal-count flag, and it does so combinationally. In the wrapper, the terminal-count flag of each stage drives the carry enable of the stage above it. One common parallel enable and one clock feed every stage. The chain therefore behaves as one counter of `STAGES*STAGE_W` bits. An upper stage steps only in a cycle where every stage below it is at all ones.

A shorter count modulus is made outside the block. The user decodes a chosen value of `count` and drives `clear_n` low from that decode. The counter then returns to zero on the next edge.

Top module: `pcnt_cascade`

## Requirements
- R1: When `clear_n` is 0 at a rising edge, `count` becomes 0 after that edge, whatever `load_n`, `en_par` and `en_carry` are.
- R2: When `clear_n` is 1 and `load_n` is 0 at an edge, `count` takes the value of `din` after that edge, even when both enables are 0.
- R3: When `clear_n`, `load_n`, `en_par` and `en_carry` are all 1 at an edge, `count` increases by exactly one.
- R4: When `clear_n` and `load_n` are 1 and either `en_par` or `en_carry` is 0 at an edge, `count` is unchanged after that edge.
- R5: Counting from the all-ones value gives 0 on the next count edge, both within a stage (15 to 0) and for the full width (0xFF to 0x00 with two stages).
- R6: `tc_out` is 1 exactly when `en_carry` is 1 and every bit of `count` is 1. A fall of `en_carry` clears `tc_out` in the same cycle, with no clock edge needed.
- R7: During counting, stage k (bits 4k+3..4k) changes only at an edge where every lower stage holds 0xF. At all other count edges it keeps its value.
- R8: If `clear_n` is driven low from an external decode of `count` equal to 9, the counter runs through 0 to 9 and returns to 0 on the edge after 9 is shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Count enable to every stage; gates counting only |
| en_carry | input | 1 | Carry enable into the lowest stage; gates counting and `tc_out` |
| din | input | STAGES*STAGE_W (8) | Parallel load value |
| count | output | STAGES*STAGE_W (8) | Counter state |
| tc_out | output | 1 | Terminal count of the top stage |

## Verification
A wrong mode decode or a corrupted stage register shows up on `count` at the first edge after the fault, because every edge ends in one of the four modes and each mode has a single, predictable result. A fault in the carry chain can stay hidden until a lower stage reaches all ones. It then appears at that very edge: an upper slice steps too early, steps too late, or fails to step, and the rollover from 0xFF to 0x00 checks this directly. A fault in the terminal-count path is visible at `tc_out` within the same cycle. This is why that flag is also checked between edges, right after `en_carry` falls.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    // Operating mode of one counter stage, selected each edge by priority.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2,
        MODE_CLEAR = 2'd3
    } mode_t;

endpackage

// File: rtl/pcnt_mode_dec.sv
module pcnt_mode_dec
    import pcnt_pkg::*;
(
    input  logic  clear_n,
    input  logic  load_n,
    input  logic  en_par,
    input  logic  en_carry,
    output mode_t mode
);

    // Fixed priority: clear, then load, then count, else hold.
    always_comb begin
        if (!clear_n) begin
            mode = MODE_CLEAR;
        end else if (!load_n) begin
            mode = MODE_LOAD;
        end else if (en_par && en_carry) begin
            mode = MODE_COUNT;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/pcnt_stage.sv
module pcnt_stage
    import pcnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic         en_par,
    input  logic         en_carry,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    mode_t        mode;
    logic [W-1:0] cnt_q;

    pcnt_mode_dec u_dec (
        .clear_n (clear_n),
        .load_n  (load_n),
        .en_par  (en_par),
        .en_carry(en_carry),
        .mode    (mode)
    );

    // State register: one transition per mode.
    always_ff @(posedge clk) begin
        unique case (mode)
            MODE_CLEAR: cnt_q <= '0;
            MODE_LOAD:  cnt_q <= din;
            MODE_COUNT: cnt_q <= cnt_q + ONE;
            MODE_HOLD:  cnt_q <= cnt_q;
        endcase
    end

    // Outputs: carry enable reaches tc without a register.
    always_comb begin
        q  = cnt_q;
        tc = en_carry && (cnt_q == ALL_ONES);
    end

    // Assertions are armed once a clear has defined the state.
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!clear_n) armed_q <= 1'b1;
    end

    p_clear_zero_r1: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        !clear_n |=> (q == '0));
    p_load_data_r2: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (clear_n && !load_n) |=> (q == $past(din)));
    p_count_step_r3: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (clear_n && load_n && en_par && en_carry) |=> (q == $past(q) + ONE));
    p_hold_value_r4: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (clear_n && load_n && !(en_par && en_carry)) |=> $stable(q));
    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (clear_n && load_n && en_par && en_carry && q == ALL_ONES) |=> (q == '0));

endmodule

// File: rtl/pcnt_cascade.sv
module pcnt_cascade #(
    parameter int STAGES  = 2,
    parameter int STAGE_W = 4
) (
    input  logic                         clk,
    input  logic                         clear_n,
    input  logic                         load_n,
    input  logic                         en_par,
    input  logic                         en_carry,
    input  logic [STAGES*STAGE_W-1:0]    din,
    output logic [STAGES*STAGE_W-1:0]    count,
    output logic                         tc_out
);

    localparam int TOT_W = STAGES * STAGE_W;

    // chain[k] is the carry enable of stage k; chain[STAGES] is the top flag.
    logic [STAGES:0] chain;

    assign chain[0] = en_carry;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        pcnt_stage #(.W(STAGE_W)) u_stage (
            .clk     (clk),
            .clear_n (clear_n),
            .load_n  (load_n),
            .en_par  (en_par),
            .en_carry(chain[g]),
            .din     (din[g*STAGE_W +: STAGE_W]),
            .q       (count[g*STAGE_W +: STAGE_W]),
            .tc      (chain[g+1])
        );
    end

    assign tc_out = chain[STAGES];

    logic armed_q;
    always_ff @(posedge clk) begin
        if (!clear_n) armed_q <= 1'b1;
    end

    // Top flag implies the carry input and a full-ones state across all stages.
    always_comb begin
        if (tc_out === 1'b1) begin
            p_tc_full_r6: assert (en_carry && (count == {TOT_W{1'b1}}));
        end
    end

    // Upper stages move on count edges only when every lower stage is full.
    for (genvar k = 1; k < STAGES; k++) begin : g_chk
        p_upper_gated_r7: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
            (clear_n && load_n && !chain[k]) |=> $stable(count[k*STAGE_W +: STAGE_W]));
    end

endmodule

// File: tb/tb_pcnt_cascade.sv
`timescale 1ns/1ps
module tb_pcnt_cascade;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clear_n, load_n, en_par, en_carry;
    logic [W-1:0] din;
    logic [W-1:0] count;
    logic         tc_out;

    int checks = 0;
    int failures = 0;
    int model = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pcnt_cascade dut (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_par(en_par),
        .en_carry(en_carry), .din(din), .count(count), .tc_out(tc_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One edge: update the behavioural model from the held inputs, then compare.
    task automatic step(input string tag);
        @(posedge clk);
        if (!clear_n)                 model = 0;
        else if (!load_n)             model = int'(din);
        else if (en_par && en_carry)  model = (model + 1) % 256;
        #1;
        chk({tag, " count"}, int'(count), model);
        chk({tag, " tc"}, int'(tc_out), (en_carry && model == 255) ? 1 : 0);
    endtask

    task automatic drive(input logic c, input logic l, input logic p,
                         input logic e, input logic [W-1:0] d);
        clear_n = c; load_n = l; en_par = p; en_carry = e; din = d;
    endtask

    initial begin
        #(5ns * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        drive(1, 1, 0, 0, 8'h00);
        #1;
        // R1: reset state
        drive(0, 1, 0, 0, 8'h00);
        step("R1 reset");
        // R1: clear beats load and enables
        drive(1, 0, 1, 1, 8'h5A); step("R2 load 5A");
        drive(0, 0, 1, 1, 8'hC3); step("R1 clear with load");
        // R2: load with both enables low
        drive(1, 0, 0, 0, 8'h0C); step("R2 load enables low");
        // R3/R5: count 0C -> 0D,0E,0F,10 (low stage wraps)
        drive(1, 1, 1, 1, 8'h00);
        for (int i = 0; i < 4; i++) step("R3 count");
        chk("R5 low wrap", int'(count), 8'h10);
        // R4: each enable low on its own
        drive(1, 1, 0, 1, 8'hFF); step("R4 en_par low");
        drive(1, 1, 1, 0, 8'hFF); step("R4 en_carry low");
        drive(1, 1, 0, 0, 8'hFF); step("R4 both low");
        // R6/R7: approach full-width rollover
        drive(1, 0, 0, 0, 8'hFD); step("R2 load FD");
        drive(1, 1, 1, 1, 8'h00);
        step("R7 lower at E upper holds");
        chk("R7 upper still F", int'(count[7:4]), 15);
        step("R6 tc at FF");
        chk("R6 tc high at FF", int'(tc_out), 1);
        en_carry = 0; #0.5;
        chk("R6 tc falls without edge", int'(tc_out), 0);
        en_carry = 1; #0.5;
        chk("R6 tc returns", int'(tc_out), 1);
        step("R5 rollover FF to 00");
        chk("R5 full wrap", int'(count), 0);
        // R7: lower at F but en_carry low -> no carry
        drive(1, 0, 0, 0, 8'h2F); step("R2 load 2F");
        drive(1, 1, 1, 0, 8'h00); step("R7 carry blocked");
        chk("R7 upper held", int'(count[7:4]), 2);
        drive(1, 1, 1, 1, 8'h00); step("R7 carry into upper");
        chk("R7 upper stepped", int'(count[7:4]), 3);
        // R8: modulus 10 by decoding 9 into clear
        drive(0, 1, 1, 1, 8'h00); step("R8 start");
        for (int i = 0; i < 14; i++) begin
            clear_n = (count != 8'd9);
            step("R8 modulus");
            chk("R8 below ten", (count < 8'd10) ? 1 : 0, 1);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule